// File: doc/BRIEF.md
# Register-Driven SPI Master with Software Chip Select

This block is an SPI master that a local processor drives through a small register bus. One register holds the configuration: transfer length, clock polarity and phase, an engine enable, and the chip-select output level. A second register, the execute register, starts one burst of the programmed length. A third, the data register, holds the outgoing bits before a burst and the sampled MISO bits after it. A read-only status register shows a busy flag.

Chip select is a plain configuration bit and does not depend on the execute command. Software lowers it, runs as many bursts as it needs, and raises it again. A burst of N bits shifts only the low N bits of the data register, so the bits above them stay unchanged. A word of any length can therefore be read as a chain of shorter bursts. For example, a 12-bit read is an 8-bit burst followed by a 4-bit burst, with software reading the data register between the two. SCLK is the system clock divided by `2*HALF_DIV`. Each bit takes one full SCLK period.

The sequencer is a three-state machine:
- `ST_IDLE`: SCLK rests at CPOL and MOSI is low.
- `ST_FIRST`: the first half of a bit. SCLK is at CPOL xor CPHA and MOSI carries the current bit.
- `ST_SECOND`: the second half of the bit. SCLK is at the opposite level.

The transitions are:
- `start`: `ST_IDLE` to `ST_FIRST`, on an accepted execute write.
- `mid`: `ST_FIRST` to `ST_SECOND`, when the half-period counter expires. MISO is captured here.
- `next`: `ST_SECOND` to `ST_FIRST`, when the counter expires and bits remain. The data register shifts here.
- `last`: `ST_SECOND` to `ST_IDLE`, on the final bit. The data register also shifts here.
- `abort`: any state to `ST_IDLE`, when the enable bit reads 0.

Top module: `sw_cs_spi_master`

## Requirements
- R1: The register map is as follows. Address 0 is the configuration register, address 1 the execute register, address 2 the data register and address 3 the status register, whose bit 0 is busy. In the configuration register, bits [2:0] give the length N (value 0 means 8 bits), bit 3 enables the engine, bit 4 is the chip-select level (1 means high), bit 5 is CPOL, bit 6 is CPHA, and bit 7 reads 0.
- R2: `spi_cs_n` always equals configuration bit 4. It changes only on configuration writes and is not affected by starting or finishing a burst.
- R3: A write to address 1 with bit 0 set, made while the engine is enabled and idle, starts a burst of N bits. Busy reads 1 for exactly `2*HALF_DIV*N` cycles, starting in the cycle after that write.
- R4: A burst produces exactly 2N SCLK edges. SCLK rests at CPOL whenever the engine is idle, and produces no edges while idle unless CPOL is rewritten.
- R5: MOSI sends data bits N-1 down to 0, most significant first, one bit per SCLK period. MOSI is 0 while idle.
- R6: MISO is sampled at the middle of each bit: on the rising edge in modes (0,0) and (1,1), and on the falling edge in modes (0,1) and (1,0). Each sampled bit enters at data bit 0 and moves the earlier bits up within the low N bits. Data bits N to 7 keep their value.
- R7: While busy, writes to the execute register and to the data register are ignored. The running burst keeps its length and its outgoing data.
- R8: While the enable bit is 0, execute writes are ignored and SCLK and MOSI stay idle. Clearing the enable bit during a burst returns the engine to idle on the clock edge after the configuration write.
- R9: Chip select stays low across consecutive bursts. An 8-bit burst followed by a 4-bit burst reads a 12-bit word: the first burst leaves its 8 bits in the data register, and the second replaces only the low 4.
- R10: After reset, the configuration register reads 0x10, the data register 0x00 and the status register 0x00, and `spi_cs_n`=1, `spi_sclk`=0, `spi_mosi`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, level set by software |

## Verification
The bench runs bursts in all four clock modes and at lengths of 1, 3, 4, 7 and 8 bits.
- A design that shifts the whole byte on a short burst would corrupt the high bits of the data register.
- A design that samples on the wrong edge would lose the first MISO bit.

It also chains an 8-bit burst and a 4-bit burst under one chip-select assertion, and checks that chip select does not move when a burst runs with it high.
- A design that ties chip select to the execute command would show a glitch on `spi_cs_n` in either test.

Finally, it issues execute and data writes during a busy burst, an execute write while disabled, and a mid-burst disable.
- A design that restarts on a second execute would give too many SCLK edges.
- A design that does not gate on the enable bit would start clocking while disabled.

// File: rtl/sw_spi_pkg.sv
package sw_spi_pkg;

    localparam int DATA_W = 8;
    localparam int LEN_W  = 3;
    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam int IDX_W  = $clog2(DATA_W);

    typedef enum logic [1:0] {
        A_CFG  = 2'd0,
        A_EXEC = 2'd1,
        A_DATA = 2'd2,
        A_STAT = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic             cpha;
        logic             cpol;
        logic             cs_lvl;
        logic             en;
        logic [LEN_W-1:0] len;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{cpha: 1'b0, cpol: 1'b0, cs_lvl: 1'b1,
                                   en: 1'b0, len: '0};

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } seq_state_e;

endpackage

// File: rtl/sw_spi_regs.sv
module sw_spi_regs
    import sw_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [6:0]        bus_wdata,
    input  logic              busy,
    input  logic [DATA_W-1:0] data_q,
    output cfg_t              cfg_q,
    output logic              exec_req,
    output logic              data_wr,
    output logic [DATA_W-1:0] bus_rdata
);

    reg_addr_e addr;
    assign addr = reg_addr_e'(bus_addr);

    // configuration register: written at any time, busy or not
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else if (bus_wr && addr == A_CFG) begin
            cfg_q <= cfg_t'(bus_wdata);
        end
    end

    // strobes qualified by engine state
    always_comb begin
        exec_req = bus_wr && (addr == A_EXEC) && bus_wdata[0] && cfg_q.en && !busy;
        data_wr  = bus_wr && (addr == A_DATA) && !busy;
    end

    // read mux
    always_comb begin
        unique case (addr)
            A_CFG:   bus_rdata = {1'b0, cfg_q};
            A_EXEC:  bus_rdata = '0;
            A_DATA:  bus_rdata = data_q;
            A_STAT:  bus_rdata = {{(DATA_W-1){1'b0}}, busy};
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sw_spi_seq.sv
module sw_spi_seq
    import sw_spi_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cfg_en,
    input  logic             cfg_cpol,
    input  logic             cfg_cpha,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             miso,
    output logic             busy,
    output logic             sclk,
    output logic             rx_bit,
    output logic             shift_en,
    output logic [CNT_W-1:0] nbits
);

    localparam int HC_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [HC_W-1:0] HC_LOAD = HC_W'(HALF_DIV - 1);

    seq_state_e       state, nxt;
    logic [HC_W-1:0]  hc;
    logic [CNT_W-1:0] bits_left;
    logic             first_lvl;
    logic             half_end;

    assign half_end = (hc == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start)    nxt = ST_FIRST;
            ST_FIRST:  if (half_end) nxt = ST_SECOND;
            ST_SECOND: if (half_end) nxt = (bits_left == CNT_W'(1)) ? ST_IDLE : ST_FIRST;
            default:   nxt = ST_IDLE;
        endcase
        if (!cfg_en) nxt = ST_IDLE;
    end

    // counters, snapshot and MISO capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hc        <= '0;
            bits_left <= '0;
            nbits     <= CNT_W'(DATA_W);
            first_lvl <= 1'b0;
            rx_bit    <= 1'b0;
        end else begin
            if (state == ST_IDLE && nxt == ST_FIRST) begin
                bits_left <= (cfg_len == '0) ? CNT_W'(DATA_W) : CNT_W'(cfg_len);
                nbits     <= (cfg_len == '0) ? CNT_W'(DATA_W) : CNT_W'(cfg_len);
                first_lvl <= cfg_cpol ^ cfg_cpha;
            end
            if (state != nxt) begin
                hc <= HC_LOAD;
            end else if (state != ST_IDLE) begin
                hc <= hc - 1'b1;
            end
            if (state == ST_SECOND && nxt == ST_FIRST) begin
                bits_left <= bits_left - 1'b1;
            end
            if (state == ST_FIRST && nxt == ST_SECOND) begin
                rx_bit <= miso;
            end
        end
    end

    // outputs
    always_comb begin
        busy     = (state != ST_IDLE);
        shift_en = 1'b0;
        unique case (state)
            ST_IDLE:   sclk = cfg_cpol;
            ST_FIRST:  sclk = first_lvl;
            ST_SECOND: begin
                sclk     = ~first_lvl;
                shift_en = half_end && cfg_en;
            end
            default:   sclk = cfg_cpol;
        endcase
    end

endmodule

// File: rtl/sw_spi_shift.sv
module sw_spi_shift
    import sw_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              shift_en,
    input  logic              rx_bit,
    input  logic [CNT_W-1:0]  nbits,
    input  logic              busy,
    output logic [DATA_W-1:0] data_q,
    output logic              mosi
);

    logic [DATA_W-1:0] shifted;
    logic [IDX_W-1:0]  top_idx;

    // per-bit shift: only the low nbits move, the rest hold
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        logic in_win;
        assign in_win = (CNT_W'(i) < nbits);
        if (i == 0) begin : g_lsb
            assign shifted[i] = in_win ? rx_bit : data_q[i];
        end else begin : g_up
            assign shifted[i] = in_win ? data_q[i-1] : data_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (data_wr) begin
            data_q <= wdata;
        end else if (shift_en) begin
            data_q <= shifted;
        end
    end

    assign top_idx = IDX_W'(nbits - CNT_W'(1));
    assign mosi    = busy & data_q[top_idx];

endmodule

// File: rtl/sw_cs_spi_master.sv
module sw_cs_spi_master
    import sw_spi_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic        spi_cs_n
);

    cfg_t              cfg_q;
    logic              exec_req;
    logic              data_wr;
    logic              seq_busy;
    logic              rx_bit;
    logic              shift_en;
    logic [CNT_W-1:0]  nbits;
    logic [DATA_W-1:0] data_q;

    sw_spi_regs i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata[6:0]),
        .busy      (seq_busy),
        .data_q    (data_q),
        .cfg_q     (cfg_q),
        .exec_req  (exec_req),
        .data_wr   (data_wr),
        .bus_rdata (bus_rdata)
    );

    sw_spi_seq #(.HALF_DIV(HALF_DIV)) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (exec_req),
        .cfg_en   (cfg_q.en),
        .cfg_cpol (cfg_q.cpol),
        .cfg_cpha (cfg_q.cpha),
        .cfg_len  (cfg_q.len),
        .miso     (spi_miso),
        .busy     (seq_busy),
        .sclk     (spi_sclk),
        .rx_bit   (rx_bit),
        .shift_en (shift_en),
        .nbits    (nbits)
    );

    sw_spi_shift i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_wr  (data_wr),
        .wdata    (bus_wdata),
        .shift_en (shift_en),
        .rx_bit   (rx_bit),
        .nbits    (nbits),
        .busy     (seq_busy),
        .data_q   (data_q),
        .mosi     (spi_mosi)
    );

    assign spi_cs_n = cfg_q.cs_lvl;

endmodule

// File: rtl/sw_spi_checker.sv
module sw_spi_checker
    import sw_spi_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       spi_sclk,
    input logic       spi_mosi,
    input logic       spi_cs_n,
    input logic       busy,
    input logic       cfg_en,
    input logic       cfg_cpol
);

    logic cfg_wr, exec_wr;
    assign cfg_wr  = bus_wr && (bus_addr == 2'(A_CFG));
    assign exec_wr = bus_wr && (bus_addr == 2'(A_EXEC));

    // R2: chip select moves only after a configuration write
    p_cs_by_cfg_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_wr) |-> $stable(spi_cs_n));

    // R3: accepted execute write makes the engine busy
    p_exec_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_wr && bus_wdata[0] && cfg_en && !busy) |=> busy);

    // R4: idle SCLK rests at CPOL
    p_idle_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (spi_sclk == cfg_cpol));

    // R4: no SCLK edges while idle without a configuration write
    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && !$past(cfg_wr)) |-> $stable(spi_sclk));

    // R5: MOSI low while idle
    p_idle_mosi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !spi_mosi);

    // R8: execute while disabled does not start
    p_disabled_no_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_wr && !cfg_en && !busy) |=> !busy);

endmodule

bind sw_cs_spi_master sw_spi_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi),
    .spi_cs_n  (spi_cs_n),
    .busy      (seq_busy),
    .cfg_en    (cfg_q.en),
    .cfg_cpol  (cfg_q.cpol)
);

// File: tb/test_sw_cs_spi_master.sv
`timescale 1ns/1ps
module test_sw_cs_spi_master;

    localparam int HALF = 2;

    // {cfg, tx data, miso bits, expected data}
    localparam logic [31:0] VEC [0:7] = '{
        32'h08A53B3B, 32'h0C960B9B, 32'h283CC5C5, 32'h48815A5A,
        32'h687EE1E1, 32'h09F001F1, 32'h0FD52AAA, 32'h6B120515
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       spi_sclk, spi_mosi, spi_cs_n;
    logic       spi_miso = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    sw_cs_spi_master #(.HALF_DIV(HALF)) i_sw_cs_spi_master (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    // slave model
    logic        samp_rise = 1'b1;
    logic [15:0] stream = '0;
    logic [15:0] mcap = '0;
    int          sidx = 0;
    int          edges = 0;
    logic        cs_rose = 1'b0;
    logic        cs_fell = 1'b0;

    task automatic on_sample();
        mcap = {mcap[14:0], spi_mosi};
        if (sidx > 0) sidx--;
        #1 spi_miso = stream[sidx];
    endtask

    always @(spi_sclk) edges++;
    always @(posedge spi_sclk) if (samp_rise) on_sample();
    always @(negedge spi_sclk) if (!samp_rise) on_sample();
    always @(posedge spi_cs_n) cs_rose = 1'b1;
    always @(negedge spi_cs_n) cs_fell = 1'b1;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle(output int cyc);
        logic [7:0] s;
        cyc = 0;
        rd(2'd3, s);
        while (s[0] && cyc < 5000) begin
            cyc++;
            @(negedge clk);
            rd(2'd3, s);
        end
    endtask

    task automatic load_stream(input logic [7:0] cfg, input logic [15:0] bits, input int n);
        samp_rise = (cfg[5] == cfg[6]);
        stream    = bits;
        sidx      = n - 1;
        spi_miso  = bits[n-1];
        mcap      = '0;
        edges     = 0;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL R3 watchdog: actual 0x0 expected 0x1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        int cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        rd(2'd0, r); chk("R10 cfg reset", r, 8'h10);
        rd(2'd2, r); chk("R10 data reset", r, 8'h00);
        rd(2'd3, r); chk("R10 status reset", r, 8'h00);
        chk("R10 cs_n", spi_cs_n, 1);
        chk("R10 sclk", spi_sclk, 0);
        chk("R10 mosi", spi_mosi, 0);

        // vector table: modes and lengths
        for (int k = 0; k < 8; k++) begin
            logic [7:0] cfg, tx, mi, ex, mask;
            int n;
            cfg  = VEC[k][31:24]; tx = VEC[k][23:16];
            mi   = VEC[k][15:8];  ex = VEC[k][7:0];
            n    = (cfg[2:0] == 3'd0) ? 8 : int'(cfg[2:0]);
            mask = 8'((1 << n) - 1);
            bus_write(2'd0, cfg);
            rd(2'd0, r); chk("R1 cfg readback", r, cfg);
            bus_write(2'd2, tx);
            load_stream(cfg, {8'h00, mi}, n);
            cs_rose = 1'b0;
            bus_write(2'd1, 8'h01);
            wait_idle(cyc);
            chk("R3 busy cycles", cyc, 2 * HALF * n);
            rd(2'd2, r); chk("R6 rx data", r, ex);
            chk("R5 mosi bits", int'(mcap[7:0] & mask), int'(tx & mask));
            chk("R4 sclk edges", edges, 2 * n);
            chk("R4 idle level", spi_sclk, cfg[5]);
            chk("R2 cs low held", {spi_cs_n, cs_rose}, 0);
        end

        // R9 chained 8 + 4 bit read under one chip select
        bus_write(2'd0, 8'h08);
        bus_write(2'd2, 8'h00);
        load_stream(8'h08, 16'h073B, 12);
        cs_rose = 1'b0;
        bus_write(2'd1, 8'h01);
        wait_idle(cyc);
        rd(2'd2, r); chk("R9 first burst", r, 8'h73);
        bus_write(2'd0, 8'h0C);
        bus_write(2'd1, 8'h01);
        wait_idle(cyc);
        rd(2'd2, r); chk("R9 second burst", r, 8'h7B);
        chk("R9 cs held low", {spi_cs_n, cs_rose}, 0);
        bus_write(2'd0, 8'h18);
        chk("R2 cs released", spi_cs_n, 1);

        // R2 chip select independent of execute
        cs_fell = 1'b0;
        bus_write(2'd2, 8'h00);
        load_stream(8'h18, 16'h00A7, 8);
        bus_write(2'd1, 8'h01);
        wait_idle(cyc);
        chk("R2 cs high during burst", {spi_cs_n, cs_fell}, 2'b10);
        rd(2'd2, r); chk("R2 burst with cs high", r, 8'hA7);

        // R7 writes while busy are ignored
        bus_write(2'd0, 8'h08);
        bus_write(2'd2, 8'h5C);
        load_stream(8'h08, 16'h00C3, 8);
        bus_write(2'd1, 8'h01);
        repeat (2) @(negedge clk);
        bus_write(2'd1, 8'h01);
        bus_write(2'd2, 8'hFF);
        wait_idle(cyc);
        repeat (4) @(negedge clk);
        chk("R7 no restart edges", edges, 16);
        rd(2'd2, r); chk("R7 data kept", r, 8'hC3);
        chk("R7 tx kept", int'(mcap[7:0]), 8'h5C);
        rd(2'd3, r); chk("R7 idle after", r, 8'h00);

        // R8 disabled: execute ignored
        bus_write(2'd0, 8'h00);
        edges = 0;
        bus_write(2'd1, 8'h01);
        rd(2'd3, r); chk("R8 no start", r, 8'h00);
        repeat (10) @(negedge clk);
        chk("R8 no edges", edges, 0);
        rd(2'd2, r); chk("R8 data unchanged", r, 8'hC3);
        chk("R8 mosi idle", spi_mosi, 0);

        // R8 abort by clearing enable mid-burst
        bus_write(2'd0, 8'h08);
        load_stream(8'h08, 16'h0000, 8);
        bus_write(2'd1, 8'h01);
        repeat (5) @(negedge clk);
        bus_write(2'd0, 8'h00);
        @(negedge clk);
        rd(2'd3, r); chk("R8 abort busy", r, 8'h00);
        chk("R8 abort sclk", spi_sclk, 0);
        chk("R8 abort mosi", spi_mosi, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule